// File: doc/BRIEF.md
# Framed serial PCM transmitter

This block turns parallel PCM samples into a one-bit serial stream framed by an external bit clock and frame-sync. Both arrive as levels that are synchronous to the system clock. The block watches for the bit-clock edge that launches each bit slot. At each such edge it samples the frame-sync and drives the data line one system clock later. Samples enter through a valid/ready handshake, one sample per transmitted word. A sample is left-aligned in its bus, so bit 31 is always the first bit sent.

Four formats are supported. I2S and left-justified are two-channel formats: with exactly two channels they use a two-phase frame, with one word starting on each frame-sync transition. DSP-A and DSP-B always send a single phase, with all channels back to back after the frame-sync. I2S and DSP-A add one bit slot of delay between frame-sync and the first bit. Left-justified and DSP-B add none. Word length is picked by a 3-bit code. The line is held low between words. When no sample is offered at the start of a word, the word is sent as zeros and an underrun strobe is raised.

Top module: `pcm_serial_tx`

## Requirements
- R1: While `rst_n` is low, `sdata`, `s_ready` and `underrun` are all 0.
- R2: `wlen_code` sets the bits per word: 0 gives 8, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32.
- R3: A word sends `s_data[31]` first and then the lower bits in descending order, one bit per slot.
- R4: With `bclk_inv`=0 the launch edge is the falling edge of `bclk`; with `bclk_inv`=1 it is the rising edge. `sdata` changes only in the system clock that follows a launch edge, and holds for the rest of the slot.
- R5: The frame-sync is active low for I2S (`fmt`=0) and active high for left-justified (`fmt`=1), DSP-A (`fmt`=2) and DSP-B (`fmt`=3). `fs_inv`=1 flips this polarity. A frame begins in the slot where the frame-sync, sampled at a launch edge, first shows its active level.
- R6: For I2S and DSP-A the first bit occupies the slot after the frame-start slot. For left-justified and DSP-B it occupies the frame-start slot itself.
- R7: In single-phase operation, `chan_m1`+1 words follow one another with no gap, starting at the frame start plus the data delay.
- R8: With `chan_m1`=1 and I2S or left-justified, the second word begins at the frame-sync's return to its inactive level, with the same data delay. For DSP formats that return starts nothing.
- R9: Outside the slots of a word, `sdata` is 0.
- R10: `s_ready` is high for exactly one system clock at each word start, and the word carries `s_data` from that clock when `s_valid` is high.
- R11: If `s_valid` is low at a word start, `underrun` pulses with `s_ready` and the word is sent as all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock level, synchronous to clk |
| fs | input | 1 | Frame-sync level, synchronous to clk |
| fmt | input | 2 | Format: 0 I2S, 1 left-justified, 2 DSP-A, 3 DSP-B |
| wlen_code | input | 3 | Word-length code |
| chan_m1 | input | 4 | Channel count minus one |
| bclk_inv | input | 1 | Launch on rising bit-clock edge when 1 |
| fs_inv | input | 1 | Invert frame-sync polarity |
| s_valid | input | 1 | Sample offered |
| s_data | input | 32 | Left-aligned sample |
| s_ready | output | 1 | Sample taken this clock (word start) |
| sdata | output | 1 | Serial data line |
| underrun | output | 1 | Word started with no sample offered |

## Verification
A wrong slot count or a stale pending-delay flag shows on the data line as a whole word displaced by one slot. The displacement appears within the first frame after the fault. A stuck word-remaining counter either truncates a single-phase frame or lets words spill past it. In both cases `s_ready` pulses the wrong number of times before the next frame-sync. A shifter that fails to clear leaves ones on the idle line in the slot that follows the last bit. The bench catches this at the next rising bit clock.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  localparam int unsigned SAMPLE_W = 32;
  localparam int unsigned CHAN_W   = 4;
  localparam int unsigned CNT_W    = $clog2(SAMPLE_W + 1);

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_DSPA = 2'd2,
    FMT_DSPB = 2'd3
  } fmt_e;

  // bits per word for a length code; codes above 5 fall back to the widest
  function automatic logic [CNT_W-1:0] wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    return CNT_W'(8);
      3'd1:    return CNT_W'(12);
      3'd2:    return CNT_W'(16);
      3'd3:    return CNT_W'(20);
      3'd4:    return CNT_W'(24);
      default: return CNT_W'(32);
    endcase
  endfunction

  // two-phase framing: stereo in the two-channel formats only
  function automatic logic dual_phase(input fmt_e f, input logic [CHAN_W-1:0] ch_m1);
    return (ch_m1 == CHAN_W'(1)) && (f == FMT_I2S || f == FMT_LJ);
  endfunction

  // one slot between frame-sync and first bit
  function automatic logic one_slot_delay(input fmt_e f);
    return (f == FMT_I2S) || (f == FMT_DSPA);
  endfunction

  // frame-sync active level is low
  function automatic logic fs_low_active(input fmt_e f, input logic inv);
    return (f == FMT_I2S) ^ inv;
  endfunction

endpackage

// File: rtl/pcm_tx_slot_timer.sv
module pcm_tx_slot_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fs,
  input  logic bclk_inv,
  input  logic fs_act_low,
  output logic launch,
  output logic act_edge,
  output logic inact_edge
);

  logic bclk_q;
  logic fs_act_q;
  logic seen_q;
  logic fs_act;

  assign fs_act     = fs ^ fs_act_low;
  assign launch     = bclk_inv ? (bclk & ~bclk_q) : (~bclk & bclk_q);
  assign act_edge   = launch & seen_q & fs_act & ~fs_act_q;
  assign inact_edge = launch & seen_q & ~fs_act & fs_act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      fs_act_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (launch) begin
        fs_act_q <= fs_act;
        seen_q   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          act_edge,
  input  logic          inact_edge,
  input  logic          dual,
  input  logic          delay1,
  input  logic [CW-1:0] chan_m1,
  input  logic          last_bit,
  output logic          word_start
);

  logic          pend_q;
  logic [CW-1:0] left_q;
  logic          phase_evt;
  logic          start_now;
  logic          start_pend;
  logic          start_cont;

  assign phase_evt  = act_edge | (dual & inact_edge);
  assign start_now  = phase_evt & ~delay1;
  assign start_pend = launch & ~phase_evt & pend_q;
  assign start_cont = launch & ~phase_evt & ~pend_q & last_bit & (left_q != '0);
  assign word_start = start_now | start_pend | start_cont;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      left_q <= '0;
    end else begin
      if (phase_evt)       pend_q <= delay1;
      else if (start_pend) pend_q <= 1'b0;

      if (start_now | start_pend) left_q <= dual ? '0 : chan_m1;
      else if (start_cont)        left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          word_start,
  input  logic          load_valid,
  input  logic [DW-1:0] load_data,
  input  logic [NW-1:0] wlen,
  output logic          sdata,
  output logic          last_bit
);

  logic [DW-1:0] sreg_q;
  logic [NW-1:0] cnt_q;

  assign sdata    = sreg_q[DW-1];
  assign last_bit = (cnt_q == NW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (word_start) begin
      sreg_q <= load_valid ? load_data : '0;
      cnt_q  <= wlen;
    end else if (launch) begin
      if (cnt_q > NW'(1)) begin
        sreg_q <= {sreg_q[DW-2:0], 1'b0};
        cnt_q  <= cnt_q - 1'b1;
      end else if (cnt_q == NW'(1)) begin
        sreg_q <= '0;
        cnt_q  <= '0;
      end
    end
  end

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
  parameter int unsigned DW = pcm_tx_pkg::SAMPLE_W,
  parameter int unsigned CW = pcm_tx_pkg::CHAN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          fs,
  input  logic [1:0]    fmt,
  input  logic [2:0]    wlen_code,
  input  logic [CW-1:0] chan_m1,
  input  logic          bclk_inv,
  input  logic          fs_inv,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          sdata,
  output logic          underrun
);

  import pcm_tx_pkg::*;

  localparam int unsigned NW = $clog2(DW + 1);

  fmt_e        fmt_sel;
  logic        fs_act_low;
  logic        dual;
  logic        delay1;
  logic [NW-1:0] wlen;

  // internal events, named for the checker
  logic launch;
  logic act_edge;
  logic inact_edge;
  logic word_start;
  logic last_bit;

  assign fmt_sel    = fmt_e'(fmt);
  assign fs_act_low = fs_low_active(fmt_sel, fs_inv);
  assign dual       = dual_phase(fmt_sel, chan_m1);
  assign delay1     = one_slot_delay(fmt_sel);
  assign wlen       = NW'(wlen_bits(wlen_code));

  pcm_tx_slot_timer u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (bclk),
    .fs         (fs),
    .bclk_inv   (bclk_inv),
    .fs_act_low (fs_act_low),
    .launch     (launch),
    .act_edge   (act_edge),
    .inact_edge (inact_edge)
  );

  pcm_tx_framer #(.CW(CW)) u_frm (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .act_edge   (act_edge),
    .inact_edge (inact_edge),
    .dual       (dual),
    .delay1     (delay1),
    .chan_m1    (chan_m1),
    .last_bit   (last_bit),
    .word_start (word_start)
  );

  pcm_tx_shifter #(.DW(DW), .NW(NW)) u_shf (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .word_start (word_start),
    .load_valid (s_valid),
    .load_data  (s_data),
    .wlen       (wlen),
    .sdata      (sdata),
    .last_bit   (last_bit)
  );

  assign s_ready  = word_start;
  assign underrun = word_start & ~s_valid;

endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          launch,
  input logic          word_start,
  input logic          last_bit,
  input logic          s_valid,
  input logic [DW-1:0] s_data,
  input logic          s_ready,
  input logic          sdata,
  input logic          underrun
);

  // R1: outputs quiet under reset
  p_quiet_reset_r1: assert property (@(posedge clk) !rst_n |-> (!s_ready && !underrun));
  p_line_reset_r1:  assert property (@(posedge clk) !rst_n |=> !sdata);

  // R3: first bit on the line is the sample MSB
  p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> (sdata == $past(s_data[DW-1])));

  // R4: line moves only after a launch edge
  p_launch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(sdata));

  // R9: line drops after the last bit when no new word follows
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && last_bit && !word_start) |=> !sdata);

  // R10: a sample is taken only in a launch slot
  p_ready_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> launch);

  // R11: an underrun word starts with a zero bit
  p_underrun_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !sdata);

endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .launch     (launch),
  .word_start (word_start),
  .last_bit   (last_bit),
  .s_valid    (s_valid),
  .s_data     (s_data),
  .s_ready    (s_ready),
  .sdata      (sdata),
  .underrun   (underrun)
);

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;

  localparam int MAXS = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk;
  logic        fs;
  logic [1:0]  fmt;
  logic [2:0]  wlen_code;
  logic [3:0]  chan_m1;
  logic        bclk_inv;
  logic        fs_inv;
  logic        s_valid;
  logic [31:0] s_data;
  logic        s_ready;
  logic        sdata;
  logic        underrun;

  always #2 clk = ~clk;

  pcm_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fs(fs), .fmt(fmt),
    .wlen_code(wlen_code), .chan_m1(chan_m1), .bclk_inv(bclk_inv),
    .fs_inv(fs_inv), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .sdata(sdata), .underrun(underrun)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int n_slots, ready_cnt, under_cnt, unstable_cnt, idx;
  bit act_low;
  bit rxb [0:MAXS-1];
  bit exb [0:MAXS-1];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hC0DE_5A3C ^ (i * 32'h2F1B_9E37) ^ {i[7:0], 24'h81_4E_17};
  endfunction

  function automatic int wbits(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic apply_reset(input logic [1:0] f, input logic [2:0] wc, input logic [3:0] cm,
                             input bit bi, input bit fi, input bit sv);
    fmt = f; wlen_code = wc; chan_m1 = cm; bclk_inv = bi; fs_inv = fi; s_valid = sv;
    act_low = (f == 2'd0) ^ fi;
    rst_n = 1'b0;
    bclk = ~bi;
    fs = act_low;
    idx = 0;
    s_data = pat(0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_slot(input bit act);
    bit hs, s0, s1, s2;
    hs = 1'b0;
    @(negedge clk);
    bclk = bclk_inv;
    fs = act ^ act_low;
    #1;
    if (s_ready) begin ready_cnt++; hs = s_valid; end
    if (underrun) under_cnt++;
    @(negedge clk);
    if (hs) begin idx++; s_data = pat(idx); end
    s0 = sdata;
    @(negedge clk);
    bclk = ~bclk_inv;
    s1 = sdata;
    @(negedge clk);
    s2 = sdata;
    if (!(s0 == s1 && s1 == s2)) unstable_cnt++;
    rxb[n_slots] = s1;
    n_slots++;
  endtask

  task automatic run_check(input int nfr, input int flen, input int alen, input int pre,
                           input string tags);
    int w, wl, d, mism, first;
    bit dual;
    logic [31:0] dat;
    int starts [0:15];
    int ns;
    n_slots = 0; ready_cnt = 0; under_cnt = 0; unstable_cnt = 0;
    for (int s = 0; s < pre; s++) do_slot(1'b0);
    for (int f = 0; f < nfr; f++)
      for (int s = 0; s < flen; s++) do_slot(s < alen);
    for (int s = 0; s < 2; s++) do_slot(1'b0);
    // expected stream from the framing rules
    for (int s = 0; s < MAXS; s++) exb[s] = 1'b0;
    wl = wbits(wlen_code);
    d = (fmt == 2'd0 || fmt == 2'd2) ? 1 : 0;
    dual = (chan_m1 == 4'd1) && (fmt == 2'd0 || fmt == 2'd1);
    w = 0;
    for (int f = 0; f < nfr; f++) begin
      int a;
      a = pre + f * flen;
      ns = 0;
      if (dual) begin
        starts[0] = a + d; starts[1] = a + alen + d; ns = 2;
      end else begin
        for (int i = 0; i <= int'(chan_m1); i++) starts[i] = a + d + i * wl;
        ns = int'(chan_m1) + 1;
      end
      for (int k = 0; k < ns; k++) begin
        dat = s_valid ? pat(w) : 32'h0;
        for (int j = 0; j < wl; j++) exb[starts[k] + j] = dat[31 - j];
        w++;
      end
    end
    mism = 0; first = -1;
    for (int s = 0; s < n_slots; s++)
      if (rxb[s] != exb[s]) begin mism++; if (first < 0) first = s; end
    check(mism == 0, tags, $sformatf("bit stream first bad slot %0d", first),
          mism, 0);
    check(ready_cnt == w, "R10", "s_ready pulses", ready_cnt, w);
    check(under_cnt == (s_valid ? 0 : w), "R11", "underrun pulses", under_cnt,
          s_valid ? 0 : w);
    check(unstable_cnt == 0, "R4", "line moved inside slot", unstable_cnt, 0);
  endtask

  task automatic t_reset();
    apply_reset(2'd0, 3'd2, 4'd1, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); bclk = ~bclk; fs = ~fs;
    end
    #1;
    check(sdata == 1'b0, "R1", "sdata in reset", sdata, 0);
    check(s_ready == 1'b0, "R1", "s_ready in reset", s_ready, 0);
    check(underrun == 1'b0, "R1", "underrun in reset", underrun, 0);
  endtask

  // I2S stereo, 12-bit words leave idle gaps in a 32-slot frame
  task automatic t_i2s_12();
    apply_reset(2'd0, 3'd1, 4'd1, 1'b0, 1'b0, 1'b1);
    run_check(2, 32, 16, 2, "R2/R3/R5/R6/R8/R9");
  endtask

  // I2S stereo, 16-bit words fill the frame
  task automatic t_i2s_16();
    apply_reset(2'd0, 3'd2, 4'd1, 1'b0, 1'b0, 1'b1);
    run_check(3, 32, 16, 2, "R2/R3/R6/R8");
  endtask

  task automatic t_lj_8();
    apply_reset(2'd1, 3'd0, 4'd1, 1'b0, 1'b0, 1'b1);
    run_check(2, 24, 12, 3, "R2/R5/R6/R8/R9");
  endtask

  task automatic t_lj_32();
    apply_reset(2'd1, 3'd5, 4'd1, 1'b0, 1'b0, 1'b1);
    run_check(2, 64, 32, 2, "R2/R3/R8");
  endtask

  task automatic t_dspa_4ch();
    apply_reset(2'd2, 3'd1, 4'd3, 1'b0, 1'b0, 1'b1);
    run_check(2, 56, 1, 2, "R6/R7/R9");
  endtask

  task automatic t_dspb_3ch();
    apply_reset(2'd3, 3'd4, 4'd2, 1'b0, 1'b0, 1'b1);
    run_check(2, 80, 1, 2, "R2/R6/R7");
  endtask

  // DSP-B stereo with a long sync: the return edge must not start a word
  task automatic t_dspb_2ch_long_fs();
    apply_reset(2'd3, 3'd2, 4'd1, 1'b0, 1'b0, 1'b1);
    run_check(2, 40, 20, 2, "R7/R8");
  endtask

  // reserved code, launch on rising edge
  task automatic t_dspb_inv_clk();
    apply_reset(2'd3, 3'd7, 4'd0, 1'b1, 1'b0, 1'b1);
    run_check(2, 40, 1, 2, "R2/R4/R9");
  endtask

  // I2S mono with inverted sync: active high, single phase
  task automatic t_i2s_fsinv();
    apply_reset(2'd0, 3'd3, 4'd0, 1'b0, 1'b1, 1'b1);
    run_check(2, 24, 12, 2, "R5/R6/R7");
  endtask

  task automatic t_underrun();
    apply_reset(2'd2, 3'd2, 4'd1, 1'b0, 1'b0, 1'b0);
    run_check(2, 40, 1, 2, "R11/R9");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b1; fs = 1'b1; fmt = 2'd0; wlen_code = 3'd0;
    chan_m1 = 4'd0; bclk_inv = 1'b0; fs_inv = 1'b0; s_valid = 1'b0; s_data = '0;
    t_reset();
    t_i2s_12();
    t_i2s_16();
    t_lj_8();
    t_lj_32();
    t_dspa_4ch();
    t_dspb_3ch();
    t_dspb_2ch_long_fs();
    t_dspb_inv_clk();
    t_i2s_fsinv();
    t_underrun();
    finish_run();
  end

endmodule